// File: doc/BRIEF.md
# Mode-Programmable SPI Write Slave

This block is the receive side of a serial peripheral slave that accepts register-write frames from a host. While chip select is low the host shifts in a 22-bit word: a 6-bit command, an 8-bit register address and 8 bits of data, most significant bit first. When chip select rises, a complete frame holding the write command and a mapped address updates a small register file, and the block emits a one-cycle write strobe carrying the address and the data.

The host may use any of four clock modes. Each mode fixes the idle level of the serial clock and the edge on which data is captured. The active mode sits in bits [1:0] of the register at address 0. It is zero after any reset. It is latched when chip select falls, so a frame that changes the mode is still received in the old mode, and only the frames that follow use the new one. Chip select, serial clock and data pass through two-flop synchronizers into a system clock that runs at least four times faster than the serial clock. Edges are found on the synchronized clock.

Top module: `spi_cfg_write_slave`

## Requirements
- R1: After reset every register reads 0, the active mode is 0 and the write strobe is low.
- R2: Mode 0 idles the clock low and captures on rising edges. Mode 1 idles low and captures on falling edges. Mode 2 idles high and captures on falling edges. Mode 3 idles high and captures on rising edges.
- R3: Writing address 0 sets the active mode to data bits [1:0], and `cur_mode` shows it. The active mode changes only through such a write.
- R4: The mode used for a frame is the active mode when chip select falls. A new mode applies only to the frames after the one that wrote it.
- R5: A frame is 22 captured bits, MSB first: command [21:16], address [15:8], data [7:0]. A command of 0x02 writes the data to the addressed register.
- R6: A frame with fewer than 22 capture edges is discarded: no register changes and no strobe is issued.
- R7: Capture edges after the 22nd are ignored. The first 22 bits decide the write.
- R8: A write is committed after chip select rises. `wr_stb` pulses high for one system clock, with `wr_addr` and `wr_data` holding the written address and data.
- R9: A complete frame with any command other than 0x02 changes no register and issues no strobe.
- R10: A write to an address of 4 or above (outside the register file) changes nothing and issues no strobe.
- R11: An asynchronous reset during a frame clears the registers, returns the mode to 0 and drops the partial frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x the serial clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cs_n | input | 1 | Chip select, active low |
| sclk | input | 1 | Serial clock from the host |
| sdi | input | 1 | Serial data from the host |
| cur_mode | output | 2 | Active clock mode for the next frame |
| wr_stb | output | 1 | One-cycle pulse for each committed write |
| wr_addr | output | 8 | Address of the last committed write |
| wr_data | output | 8 | Data of the last committed write |
| regs_flat | output | 32 | Register file; register i sits in bits [8i+7:8i] |

## Verification
The assertions assume that the host leaves at least a few system clocks between chip select edges and serial clock edges. They also assume that each clock level lasts at least two system clocks. Under these conditions the synchronizers never merge two events into one cycle. The stimulus keeps the clock at one tenth of the system clock rate. It puts every input change on a falling system clock edge, and it holds data for two system clocks on each side of the capture edge. On the non-capture edge it drives the inverted data bit, so a design that captures on the wrong edge receives a corrupted frame.

// File: rtl/spi_cfg_write_slave.sv
`timescale 1ns/1ps
module spi_cfg_write_slave #(
  parameter int NUM_REGS = 4,
  parameter int DW = 8,
  parameter int AW = 8,
  parameter int CW = 6,
  parameter logic [CW-1:0] WR_CMD = 6'h02
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   cs_n,
  input  logic                   sclk,
  input  logic                   sdi,
  output logic [1:0]             cur_mode,
  output logic                   wr_stb,
  output logic [AW-1:0]          wr_addr,
  output logic [DW-1:0]          wr_data,
  output logic [NUM_REGS*DW-1:0] regs_flat
);
  localparam int FRAME = CW + AW + DW;
  localparam int CNT_W = $clog2(FRAME + 1);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(FRAME);
  localparam logic [AW:0] NREG_LIM = (AW+1)'(NUM_REGS);

  logic [1:0]       cs_sy, ck_sy, di_sy;
  logic             cs_q, ck_q;
  logic [1:0]       frm_mode;
  logic [CNT_W-1:0] cnt;
  logic [FRAME-1:0] shr;
  logic [DW-1:0]    regs [NUM_REGS];

  wire cs_s = cs_sy[1];
  wire ck_s = ck_sy[1];
  wire di_s = di_sy[1];

  wire cs_fall = cs_q & ~cs_s;
  wire cs_rise = ~cs_q & cs_s;
  wire ck_rise = ck_s & ~ck_q;
  wire ck_fall = ~ck_s & ck_q;
  wire on_rise = (frm_mode[1] == frm_mode[0]);
  wire cap     = ~cs_s & ~cs_q & (on_rise ? ck_rise : ck_fall);
  wire full    = (cnt == FULL_CNT);

  wire [CW-1:0] f_cmd  = shr[FRAME-1 -: CW];
  wire [AW-1:0] f_addr = shr[DW +: AW];
  wire [DW-1:0] f_data = shr[DW-1:0];
  wire          hit    = full & (f_cmd == WR_CMD) & ({1'b0, f_addr} < NREG_LIM);
  wire          commit = cs_rise & hit;

  assign cur_mode = regs[0][1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_sy <= 2'b11;
      ck_sy <= 2'b00;
      di_sy <= 2'b00;
      cs_q  <= 1'b1;
      ck_q  <= 1'b0;
    end else begin
      cs_sy <= {cs_sy[0], cs_n};
      ck_sy <= {ck_sy[0], sclk};
      di_sy <= {di_sy[0], sdi};
      cs_q  <= cs_s;
      ck_q  <= ck_s;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frm_mode <= 2'b00;
      cnt      <= '0;
      shr      <= '0;
    end else if (cs_fall) begin
      frm_mode <= cur_mode;
      cnt      <= '0;
    end else if (cap && !full) begin
      shr <= {shr[FRAME-2:0], di_s};
      cnt <= cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_REGS; i++) regs[i] <= '0;
      wr_stb  <= 1'b0;
      wr_addr <= '0;
      wr_data <= '0;
    end else begin
      wr_stb <= commit;
      if (commit) begin
        wr_addr <= f_addr;
        wr_data <= f_data;
        for (int i = 0; i < NUM_REGS; i++)
          if (f_addr == AW'(i)) regs[i] <= f_data;
      end
    end
  end

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_flat
    assign regs_flat[g*DW +: DW] = regs[g];
  end

  AST_STB_AFTER_RISE: assert property (@(posedge clk) disable iff (!rst_n) wr_stb |-> $past(cs_rise) && $past(full)); // R8
  AST_STB_PULSE: assert property (@(posedge clk) disable iff (!rst_n) wr_stb |=> !wr_stb); // R8
  AST_SHORT_DISCARD: assert property (@(posedge clk) disable iff (!rst_n) (cs_rise && !full) |=> !wr_stb); // R6
  AST_FRAME_MODE_HELD: assert property (@(posedge clk) disable iff (!rst_n) (!cs_s && !cs_q) |=> $stable(frm_mode)); // R4
  AST_MODE_BY_WRITE: assert property (@(posedge clk) disable iff (!rst_n) (cur_mode != $past(cur_mode)) |-> (wr_stb && wr_addr == '0)); // R3
  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n) (cnt == FULL_CNT) |=> (cnt == FULL_CNT) || $past(cs_fall)); // R7
  AST_MAPPED_ONLY: assert property (@(posedge clk) disable iff (!rst_n) wr_stb |-> ({1'b0, wr_addr} < NREG_LIM)); // R10
  AST_WRITE_CMD: assert property (@(posedge clk) disable iff (!rst_n) wr_stb |-> $past(f_cmd) == WR_CMD); // R9
endmodule

// File: tb/test_spi_cfg_write_slave.sv
`timescale 1ns/1ps
module test_spi_cfg_write_slave;
  logic clk = 1'b0, rst_n = 1'b0, cs_n = 1'b1, sclk = 1'b0, sdi = 1'b0;
  logic [1:0]  cur_mode;
  logic        wr_stb;
  logic [7:0]  wr_addr, wr_data;
  logic [31:0] regs_flat;

  int n_chk = 0, n_fail = 0, stb_cnt = 0;
  logic [7:0] last_a, last_d;
  logic [7:0] ex [4];

  always #5 clk = ~clk;

  spi_cfg_write_slave i_spi_cfg_write_slave (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .sdi(sdi),
    .cur_mode(cur_mode), .wr_stb(wr_stb), .wr_addr(wr_addr), .wr_data(wr_data),
    .regs_flat(regs_flat));

  always @(negedge clk) if (wr_stb) begin
    stb_cnt++;
    last_a = wr_addr;
    last_d = wr_data;
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic check_state(input string req);
    logic [31:0] e;
    e = {ex[3], ex[2], ex[1], ex[0]};
    chk(regs_flat === e, req, regs_flat, e);
    chk(cur_mode === ex[0][1:0], req, {30'd0, cur_mode}, {30'd0, ex[0][1:0]});
  endtask

  task automatic send(input logic [1:0] pm, input logic [21:0] w, input int nedge);
    logic idle, lead, b;
    idle = pm[1];
    lead = ~pm[0];
    @(negedge clk);
    sclk = idle; sdi = 1'b0;
    #40 cs_n = 1'b0;
    #80;
    for (int i = 0; i < nedge; i++) begin
      b = (i < 22) ? w[21-i] : i[0];
      sdi = lead ? b : ~b;
      #40 sclk = ~idle;
      #20 sdi = lead ? ~b : b;
      #20 sclk = idle;
      #20;
    end
    #40 cs_n = 1'b1;
    #100;
  endtask

  task automatic frame(input logic [1:0] pm, input logic [5:0] c, input logic [7:0] a,
                       input logic [7:0] d, input int nedge, input int exp_stb, input string req);
    int s0;
    s0 = stb_cnt;
    send(pm, {c, a, d}, nedge);
    chk(stb_cnt - s0 == exp_stb, req, stb_cnt - s0, exp_stb);
    if (exp_stb == 1) chk({last_a, last_d} === {a, d}, req, {last_a, last_d}, {a, d});
  endtask

  initial begin
    #2_000_000;
    n_fail++;
    $display("FAIL watchdog actual running expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [1:0] am;
    logic [7:0] dv;
    for (int i = 0; i < 4; i++) ex[i] = 8'h00;
    #35 rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check_state("R1 reset");
    chk(wr_stb === 1'b0, "R1 strobe", {31'd0, wr_stb}, 0);

    am = 2'd0;
    for (int m = 0; m < 4; m++) begin
      frame(am, 6'h02, 8'h00, 8'(m), 22, 1, "R3 mode write");
      ex[0] = 8'(m);
      am = 2'(m);
      check_state("R3 mode");
      for (int a = 1; a < 4; a++)
        for (int k = 0; k < 6; k++) begin
          dv = 8'((k * 53 + a * 17 + m * 91) & 8'hFF);
          frame(am, 6'h02, 8'(a), dv, 22, 1, "R2 R5 sweep");
          ex[a] = dv;
          check_state("R2 R5 sweep");
        end
    end

    frame(am, 6'h02, 8'h00, 8'h01, 22, 1, "R4 set mode 1");
    ex[0] = 8'h01; am = 2'd1;
    check_state("R4 set mode 1");
    frame(2'd0, 6'h02, 8'h01, 8'h55, 22, 0, "R4 old protocol rejected");
    check_state("R4 old protocol rejected");
    frame(2'd1, 6'h02, 8'h00, 8'h00, 22, 1, "R4 back to mode 0");
    ex[0] = 8'h00; am = 2'd0;
    frame(2'd0, 6'h02, 8'h01, 8'h66, 22, 1, "R4 next frame mode 0");
    ex[1] = 8'h66;
    check_state("R4 next frame mode 0");

    frame(2'd0, 6'h02, 8'h02, 8'h99, 21, 0, "R6 short frame");
    check_state("R6 short frame");
    frame(2'd0, 6'h02, 8'h02, 8'hA7, 25, 1, "R7 long frame");
    ex[2] = 8'hA7;
    check_state("R7 long frame");
    frame(2'd0, 6'h03, 8'h02, 8'h11, 22, 0, "R9 other command");
    frame(2'd0, 6'h00, 8'h03, 8'h22, 22, 0, "R9 zero command");
    check_state("R9 command");
    frame(2'd0, 6'h02, 8'h04, 8'h33, 22, 0, "R10 address 4");
    frame(2'd0, 6'h02, 8'hFF, 8'h44, 22, 0, "R10 address FF");
    check_state("R10 unmapped");

    frame(2'd0, 6'h02, 8'h00, 8'h02, 22, 1, "R11 set mode 2");
    ex[0] = 8'h02;
    check_state("R11 set mode 2");
    @(negedge clk);
    sclk = 1'b1;
    #40 cs_n = 1'b0;
    #80 sclk = 1'b0;
    #50 sclk = 1'b1;
    #50 rst_n = 1'b0;
    #30 rst_n = 1'b1;
    cs_n = 1'b1; sclk = 1'b0;
    #100;
    for (int i = 0; i < 4; i++) ex[i] = 8'h00;
    check_state("R11 reset mid frame");
    frame(2'd0, 6'h02, 8'h03, 8'h3C, 22, 1, "R11 mode 0 after reset");
    ex[3] = 8'h3C;
    check_state("R11 mode 0 after reset");

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule